// File: doc/BRIEF.md
# Debug Memory Access Command Engine

This block lets an external debug host read and write the target system bus without the CPU's help. The host pushes bytes over a valid/ready stream. Each command is an opcode byte, then a 16-bit address, then (for writes only) a 16-bit data word. All multi-byte fields arrive most significant byte first. Once the last byte has arrived, the engine waits for the CPU to announce a free bus cycle. If no free cycle has come after a bounded wait, it takes a cycle by force.

Every read gives back a full 16-bit word in a holding register. For a byte read, only the addressed lane holds data and the other lane is zero. Word accesses at an odd address are quietly realigned to the even word. While a command is in flight, the host side refuses new bytes. This makes the handshake itself the pacing that a host would otherwise have to do by counting cycles.

Top module: `dbg_cmd_engine`

## Requirements
- R1: Opcode 0xE0 reads a byte, 0xE8 reads a word, 0xC0 writes a byte and 0xC8 writes a word. A read takes two further bytes (the address). A write takes four (the address, then the data). Fields are taken high byte first.
- R2: An opcode byte with any other value is consumed and dropped. The engine stays ready for an opcode, and no bus cycle follows.
- R3: `host_ready` is low from the cycle after the last command byte is accepted until the bus access is finished. For a write, that is the access cycle. For a read, it is the cycle in which the result is loaded.
- R4: While a command waits for the bus, `bus_free` high in a cycle makes `bus_en` high in the next cycle, with `bus_steal` low.
- R5: Suppose `bus_free` stays low for STEAL_WAIT (default 128) waiting cycles. The access is then forced in the next cycle, with `bus_steal` high. Free in the last waiting cycle still counts as a free cycle.
- R6: A byte read returns the addressed byte in `result_word[15:8]` for an even address and in `result_word[7:0]` for an odd address. The other half is zero.
- R7: A word read or write puts out the address with bit 0 cleared and `bus_be` = 2'b11. A word read returns the whole word, with bits 15:8 from the even byte.
- R8: A byte write drives exactly one byte enable. It uses `bus_be[1]` (bits 15:8) for an even address and `bus_be[0]` for an odd one. That lane carries the low byte of the received data word.
- R9: A read result is loaded into `result_word` two cycles after its bus cycle, with `result_valid` high for that one cycle. The whole command finishes within DEADLINE (default 150) cycles of its last byte.
- R10: A synchronous active-high `rst` clears `result_word`, lowers `result_valid` and `bus_en`, and leaves the engine waiting for an opcode with `host_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host byte is valid |
| host_byte | input | 8 | Command byte from host |
| host_ready | output | 1 | Engine accepts a byte this cycle |
| bus_free | input | 1 | CPU leaves the next bus cycle unused |
| bus_en | output | 1 | Bus access cycle |
| bus_we | output | 1 | Access is a write (valid with bus_en) |
| bus_addr | output | 16 | Byte address of the access |
| bus_be | output | 2 | Lane enables, bit 1 = bits 15:8 |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid the cycle after bus_en |
| bus_steal | output | 1 | The current access was forced |
| result_word | output | 16 | Holding register for read results |
| result_valid | output | 1 | Pulse: result_word was just loaded |

## Verification
Several rules are checked by assertions on every cycle:
- no bus cycle while the host side is open;
- a free flag turns into an unforced access one cycle later;
- an exhausted wait turns into a forced access;
- word addresses come out even;
- byte accesses enable exactly one lane;
- byte results carry zero in the unused half;
- a command finishes inside the deadline.

Only the bench scenarios can show the other properties. These are whether the right byte reaches memory and comes back on the right lane, whether a dropped opcode really leaves the byte stream aligned, the exact cycle of each access against a chosen free pattern, and that reset empties the holding register.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam logic [7:0] OP_RD_BYTE = 8'hE0;
  localparam logic [7:0] OP_RD_WORD = 8'hE8;
  localparam logic [7:0] OP_WR_BYTE = 8'hC0;
  localparam logic [7:0] OP_WR_WORD = 8'hC8;

  typedef struct packed {
    logic is_write;
    logic is_word;
  } cmd_kind_t;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_RD_BYTE) || (op == OP_RD_WORD) ||
           (op == OP_WR_BYTE) || (op == OP_WR_WORD);
  endfunction

  function automatic cmd_kind_t op_kind(input logic [7:0] op);
    cmd_kind_t k;
    k.is_write = (op == OP_WR_BYTE) || (op == OP_WR_WORD);
    k.is_word  = (op == OP_RD_WORD) || (op == OP_WR_WORD);
    return k;
  endfunction
endpackage

// File: rtl/dbg_host_rx.sv
module dbg_host_rx
  import dbg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  input  logic              exec_done,
  output logic              cmd_go,
  output logic              cmd_write,
  output logic              cmd_word,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int DATA_BYTES = DATA_W / 8;
  localparam int MAX_BYTES  = (ADDR_BYTES > DATA_BYTES) ? ADDR_BYTES : DATA_BYTES;
  localparam int CNT_W      = $clog2(MAX_BYTES + 1);

  typedef enum logic [1:0] {RX_OPC, RX_ADDR, RX_DATA, RX_EXEC} rx_state_e;

  rx_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             take;
  logic             addr_last;
  logic             data_last;
  cmd_kind_t        kind;

  assign in_ready  = (st_q != RX_EXEC);
  assign take      = in_valid && in_ready;
  assign addr_last = (cnt_q == CNT_W'(ADDR_BYTES - 1));
  assign data_last = (cnt_q == CNT_W'(DATA_BYTES - 1));
  assign kind      = op_kind(in_byte);
  assign cmd_go    = take && (((st_q == RX_ADDR) && addr_last && !cmd_write) ||
                              ((st_q == RX_DATA) && data_last));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= RX_OPC;
      cnt_q     <= '0;
      cmd_write <= 1'b0;
      cmd_word  <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
    end else begin
      case (st_q)
        RX_OPC: begin
          if (take && op_known(in_byte)) begin
            cmd_write <= kind.is_write;
            cmd_word  <= kind.is_word;
            cnt_q     <= '0;
            st_q      <= RX_ADDR;
          end
        end
        RX_ADDR: begin
          if (take) begin
            cmd_addr <= {cmd_addr[ADDR_W-9:0], in_byte};
            if (addr_last) begin
              cnt_q <= '0;
              st_q  <= cmd_write ? RX_DATA : RX_EXEC;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (take) begin
            cmd_data <= {cmd_data[DATA_W-9:0], in_byte};
            if (data_last) begin
              cnt_q <= '0;
              st_q  <= RX_EXEC;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: begin
          if (exec_done) st_q <= RX_OPC;
        end
      endcase
    end
  end

  // R2
  bad_opcode_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == RX_OPC) && take && !op_known(in_byte) |=> (st_q == RX_OPC));

  // R1
  go_once_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> !in_ready);
endmodule

// File: rtl/dbg_steal_arb.sv
module dbg_steal_arb #(
  parameter int STEAL_WAIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bus_free,
  output logic grant,
  output logic stolen
);
  localparam int WCNT_W = $clog2(STEAL_WAIT + 1);

  logic              armed_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic              limit_hit;

  assign limit_hit = (wcnt_q == WCNT_W'(STEAL_WAIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      wcnt_q  <= '0;
      grant   <= 1'b0;
      stolen  <= 1'b0;
    end else begin
      grant  <= 1'b0;
      stolen <= 1'b0;
      if (start) begin
        armed_q <= 1'b1;
        wcnt_q  <= '0;
      end else if (armed_q) begin
        if (bus_free || limit_hit) begin
          armed_q <= 1'b0;
          grant   <= 1'b1;
          stolen  <= !bus_free;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
    end
  end

  // R4
  free_grant_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q && bus_free && !start |=> grant && !stolen);

  // R5
  forced_grant_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q && !bus_free && limit_hit && !start |=> grant && stolen);

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> wcnt_q < WCNT_W'(STEAL_WAIT));
endmodule

// File: rtl/dbg_bus_exec.sv
module dbg_bus_exec #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                grant,
  input  logic                stolen,
  input  logic                cmd_write,
  input  logic                cmd_word,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DATA_W-1:0]   cmd_data,
  output logic                bus_en,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_steal,
  output logic [DATA_W-1:0]   result_word,
  output logic                result_valid,
  output logic                exec_done
);
  localparam int LANES = DATA_W / 8;
  localparam int LB    = $clog2(LANES);

  logic [LB-1:0]     lane_off;
  logic [LANES-1:0]  lane_sel;
  logic [DATA_W-1:0] rd_fmt;
  logic [DATA_W-1:0] sel_bits;
  logic              rd_pend_q;

  assign lane_off = cmd_addr[LB-1:0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_sel[i]          = cmd_word || (lane_off == LB'(LANES - 1 - i));
    assign bus_wdata[i*8 +: 8]  = cmd_word ? cmd_data[i*8 +: 8] : cmd_data[7:0];
    assign rd_fmt[i*8 +: 8]     = lane_sel[i] ? bus_rdata[i*8 +: 8] : 8'h00;
    assign sel_bits[i*8 +: 8]   = {8{lane_sel[i]}};
  end

  assign bus_en    = grant;
  assign bus_we    = cmd_write;
  assign bus_steal = stolen;
  assign bus_be    = lane_sel;
  assign bus_addr  = cmd_word ? {cmd_addr[ADDR_W-1:LB], {LB{1'b0}}} : cmd_addr;
  assign exec_done = (grant && cmd_write) || rd_pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend_q    <= 1'b0;
      result_word  <= '0;
      result_valid <= 1'b0;
    end else begin
      rd_pend_q    <= grant && !cmd_write;
      result_valid <= rd_pend_q;
      if (rd_pend_q) result_word <= rd_fmt;
    end
  end

  // R7
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en && cmd_word |-> (bus_addr[LB-1:0] == '0) && (&bus_be));

  // R8
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en && !cmd_word |-> $countones(bus_be) == 1);

  // R6
  byte_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid && !cmd_word |-> (result_word & ~sel_bits) == '0);

  // R9
  result_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
endmodule

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int STEAL_WAIT = 128,
  parameter int DEADLINE   = 150
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                host_valid,
  input  logic [7:0]          host_byte,
  output logic                host_ready,
  input  logic                bus_free,
  output logic                bus_en,
  output logic                bus_we,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_steal,
  output logic [DATA_W-1:0]   result_word,
  output logic                result_valid
);
  localparam int LAT_W = $clog2(DEADLINE + 2);

  logic              cmd_go;
  logic              cmd_write;
  logic              cmd_word;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data;
  logic              exec_done;
  logic              grant;
  logic              stolen;

  dbg_host_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (host_valid),
    .in_byte   (host_byte),
    .in_ready  (host_ready),
    .exec_done (exec_done),
    .cmd_go    (cmd_go),
    .cmd_write (cmd_write),
    .cmd_word  (cmd_word),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data)
  );

  dbg_steal_arb #(.STEAL_WAIT(STEAL_WAIT)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .start    (cmd_go),
    .bus_free (bus_free),
    .grant    (grant),
    .stolen   (stolen)
  );

  dbg_bus_exec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_exec (
    .clk          (clk),
    .rst          (rst),
    .grant        (grant),
    .stolen       (stolen),
    .cmd_write    (cmd_write),
    .cmd_word     (cmd_word),
    .cmd_addr     (cmd_addr),
    .cmd_data     (cmd_data),
    .bus_en       (bus_en),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_be       (bus_be),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_steal    (bus_steal),
    .result_word  (result_word),
    .result_valid (result_valid),
    .exec_done    (exec_done)
  );

  logic             lat_on_q;
  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_on_q <= 1'b0;
      lat_q    <= '0;
    end else if (cmd_go) begin
      lat_on_q <= 1'b1;
      lat_q    <= '0;
    end else if (lat_on_q) begin
      if (exec_done) lat_on_q <= 1'b0;
      else           lat_q    <= lat_q + 1'b1;
    end
  end

  // R9
  deadline_chk: assert property (@(posedge clk) disable iff (rst)
    lat_on_q |-> lat_q < LAT_W'(DEADLINE));

  // R3
  closed_during_access_chk: assert property (@(posedge clk) disable iff (rst)
    bus_en |-> !host_ready);
endmodule

// File: tb/sim_dbg_cmd_engine.sv
module sim_dbg_cmd_engine;
  localparam int SW = 128;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic [7:0]  host_byte = 8'h00;
  logic        host_ready;
  logic        bus_free = 1'b0;
  logic        bus_en, bus_we, bus_steal, result_valid;
  logic [15:0] bus_addr, bus_wdata, result_word;
  logic [15:0] bus_rdata = 16'h0000;
  logic [1:0]  bus_be;

  always #4 clk = ~clk;

  dbg_cmd_engine #(.ADDR_W(16), .DATA_W(16), .STEAL_WAIT(SW), .DEADLINE(150)) u0 (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_byte(host_byte),
    .host_ready(host_ready), .bus_free(bus_free), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_steal(bus_steal), .result_word(result_word), .result_valid(result_valid)
  );

  int checks = 0;
  int errors = 0;

  logic [15:0] mem    [logic [14:0]];
  logic [15:0] shadow [logic [14:0]];

  function automatic logic [15:0] init_word(input logic [14:0] w);
    return {w[7:0] ^ 8'h3C, w[14:7] ^ 8'hA5};
  endfunction

  function automatic logic [15:0] mem_word(input logic [14:0] w);
    return mem.exists(w) ? mem[w] : init_word(w);
  endfunction

  function automatic logic [15:0] shadow_word(input logic [14:0] w);
    return shadow.exists(w) ? shadow[w] : init_word(w);
  endfunction

  // target memory: reads answer one cycle after bus_en
  always @(posedge clk) begin
    if (bus_en) begin
      if (bus_we) begin
        logic [15:0] cur;
        cur = mem_word(bus_addr[15:1]);
        if (bus_be[1]) cur[15:8] = bus_wdata[15:8];
        if (bus_be[0]) cur[7:0]  = bus_wdata[7:0];
        mem[bus_addr[15:1]] = cur;
      end else begin
        bus_rdata <= mem_word(bus_addr[15:1]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    host_valid = 1'b1;
    host_byte  = b;
    while (!host_ready) @(negedge clk);
    @(posedge clk);
    #1 host_valid = 1'b0;
  endtask

  // free_after: cycle index (1 = first waiting cycle) at which bus_free rises
  task automatic run_cmd(input logic [7:0] op, input logic [15:0] addr,
                         input logic [15:0] data, input int free_after);
    logic wr, wd;
    int k_exp;
    logic early_bad;
    logic [15:0] exp_addr, w, exp_res;
    logic [1:0] exp_be;
    wr = (op == 8'hC0) || (op == 8'hC8);
    wd = (op == 8'hE8) || (op == 8'hC8);
    bus_free = 1'b0;
    send_byte(op);
    send_byte(addr[15:8]);
    send_byte(addr[7:0]);
    if (wr) begin
      send_byte(data[15:8]);
      send_byte(data[7:0]);
    end
    k_exp = (free_after > SW) ? SW + 1 : free_after + 1;
    exp_addr = wd ? {addr[15:1], 1'b0} : addr;
    exp_be   = wd ? 2'b11 : (addr[0] ? 2'b01 : 2'b10);
    early_bad = 1'b0;
    for (int k = 1; k <= k_exp; k++) begin
      @(negedge clk);
      if (k < k_exp) begin
        if (host_ready !== 1'b0 || bus_en !== 1'b0) early_bad = 1'b1;
      end else begin
        chk("R3 ready low while waiting", {31'd0, early_bad}, 32'd0);
        chk("R4/R5 access cycle", {31'd0, bus_en}, 32'd1);
        chk("R5 steal flag", {31'd0, bus_steal}, {31'd0, (free_after > SW)});
        chk("R1/R7 bus address", {16'd0, bus_addr}, {16'd0, exp_addr});
        chk("R7/R8 byte enables", {30'd0, bus_be}, {30'd0, exp_be});
        chk("R1 write flag", {31'd0, bus_we}, {31'd0, wr});
        if (wr) begin
          if (wd) chk("R1/R7 write data", {16'd0, bus_wdata}, {16'd0, data});
          else if (addr[0]) chk("R8 odd lane data", {24'd0, bus_wdata[7:0]}, {24'd0, data[7:0]});
          else chk("R8 even lane data", {24'd0, bus_wdata[15:8]}, {24'd0, data[7:0]});
        end
      end
      bus_free = (k >= free_after);
    end
    bus_free = 1'b0;
    w = shadow_word(addr[15:1]);
    if (wr) begin
      if (wd) w = data;
      else if (addr[0]) w[7:0] = data[7:0];
      else w[15:8] = data[7:0];
      shadow[addr[15:1]] = w;
      @(negedge clk);
      chk("R3 ready back after write", {31'd0, host_ready}, 32'd1);
      chk("R9 no result on write", {31'd0, result_valid}, 32'd0);
    end else begin
      exp_res = wd ? w : (addr[0] ? {8'h00, w[7:0]} : {w[15:8], 8'h00});
      @(negedge clk);
      chk("R3 ready low until load", {31'd0, host_ready}, 32'd0);
      chk("R9 result not yet valid", {31'd0, result_valid}, 32'd0);
      @(negedge clk);
      chk("R9 result valid pulse", {31'd0, result_valid}, 32'd1);
      chk(wd ? "R7 word result" : "R6 byte result", {16'd0, result_word}, {16'd0, exp_res});
      chk("R3 ready after load", {31'd0, host_ready}, 32'd1);
      @(negedge clk);
      chk("R9 pulse ends", {31'd0, result_valid}, 32'd0);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (2000 * SW) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ready after reset", {31'd0, host_ready}, 32'd1);
    chk("R10 holding cleared", {16'd0, result_word}, 32'd0);
    chk("R10 no bus cycle", {31'd0, bus_en}, 32'd0);
    rst = 1'b0;

    run_cmd(8'hE8, 16'h1234, 16'h0000, 1);     // R1 word read, free at once
    run_cmd(8'hC0, 16'h1234, 16'hBEEF, 3);     // R8 even byte write
    run_cmd(8'hE8, 16'h1234, 16'h0000, 2);
    run_cmd(8'hC0, 16'h1235, 16'h0077, 999);   // R5 forced, odd byte write
    run_cmd(8'hE0, 16'h1234, 16'h0000, 5);     // R6 even byte read
    run_cmd(8'hE0, 16'h1235, 16'h0000, 129);   // R6 odd byte read, forced
    run_cmd(8'hC8, 16'h2001, 16'hCAFE, 2);     // R7 odd word write realigned
    run_cmd(8'hE8, 16'h2000, 16'h0000, 1);
    run_cmd(8'hE8, 16'h2001, 16'h0000, 128);   // R5 free in last waiting cycle

    // R2 unknown opcodes are dropped and leave the stream aligned
    held = result_word;
    send_byte(8'h55);
    @(negedge clk);
    chk("R2 ready after bad opcode", {31'd0, host_ready}, 32'd1);
    chk("R2 no bus cycle", {31'd0, bus_en}, 32'd0);
    send_byte(8'hC1);
    repeat (3) @(negedge clk);
    chk("R2 no bus cycle later", {31'd0, bus_en}, 32'd0);
    chk("R2 holding unchanged", {16'd0, result_word}, {16'd0, held});
    run_cmd(8'hE0, 16'h2001, 16'h0000, 4);

    // R10 reset clears a loaded holding register
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 holding cleared mid-run", {16'd0, result_word}, 32'd0);
    chk("R10 ready after mid reset", {31'd0, host_ready}, 32'd1);
    run_cmd(8'hE8, 16'h0100, 16'h0000, 7);

    finish_run();
  end
endmodule